// File: doc/BRIEF.md
# Memory Clock Multiplier Selector

This controller picks the DRAM clock multiplier once, at memory initialization. For every installed module it chooses between the standard timing profile and an optional performance profile. It then takes the slowest module's frequency, clamps it to the board or fuse ceiling and turns the result into the largest multiplier that the chosen reference clock allows.

After a start pulse the controller drives the multiplier request and enables the PLL. It then waits a programmable number of cycles for lock. If lock does not come, it drops the enable for one cycle, lowers the multiplier by one and tries again. A lock freezes the result until reset. A failure flag is raised if no usable multiplier locks.

Top module: `mclk_mult_sel`

## Requirements
- R1: After reset, `mult` is 0 and `pll_en`, `done` and `fail` are all 0.
- R2: A module uses its performance frequency only when all three of these hold: `perf_avail` is set for it, `perf_v15` is set for it, and the number of present modules in its channel does not exceed its `perf_lim`. Otherwise it uses `std_fmax`. Module i sits in channel i / NSLOT, and field i occupies bits [i*FW +: FW] (limits [i*CW +: CW]).
- R3: With `cfg_ign_lim` set, the module-count check of R2 is skipped.
- R4: The target frequency is the minimum selected frequency over the present modules.
- R5: A nonzero `board_fmax` is the ceiling. When `board_fmax` is zero, `fuse_fmax` is the ceiling unless `cfg_ign_fuse` is set, in which case there is no ceiling.
- R6: The first multiplier is the largest m with ref*m <= clamped target, capped at MULT_MAX. The reference is 133 MHz when `ref_sel`=0 and 100 MHz when `ref_sel`=1.
- R7: Each attempt holds `pll_en` high for `lock_wait` cycles. Without lock, `pll_en` falls for one cycle and `mult` decreases by exactly 1 before the next attempt.
- R8: On lock, `done` rises and `mult` and `pll_en` hold. Later `start` pulses, input changes and loss of lock change nothing until reset.
- R9: `fail` rises and holds, with `pll_en` low, in three cases: no module is present, the first multiplier is below MULT_MIN, or the attempt at MULT_MIN times out.
- R10: `done` and `fail` are never both high, and `mult` only changes while `pll_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin selection (honoured only when idle) |
| dimm_present | input | ND | Module installed, one bit per slot |
| std_fmax | input | ND*FW | Standard-profile max frequency per module, MHz |
| perf_avail | input | ND | Performance profile present per module |
| perf_v15 | input | ND | Performance profile specifies 1.5 V |
| perf_fmax | input | ND*FW | Performance-profile max frequency per module, MHz |
| perf_lim | input | ND*CW | Performance-profile module-per-channel limit |
| cfg_ign_lim | input | 1 | Skip the module-count check |
| cfg_ign_fuse | input | 1 | Skip the fuse ceiling |
| fuse_fmax | input | FW | Fuse frequency ceiling, MHz |
| board_fmax | input | FW | Board override ceiling, 0 = none |
| ref_sel | input | 1 | 0 = 133 MHz, 1 = 100 MHz reference |
| lock_wait | input | LW | Cycles per lock attempt |
| pll_lock | input | 1 | PLL lock indication |
| mult | output | MW | Multiplier request |
| pll_en | output | 1 | PLL enable |
| done | output | 1 | Multiplier locked and frozen |
| fail | output | 1 | No multiplier locked |

## Verification
The hardest path to reach is a long chain of failed lock attempts that ends either in a late lock or in a timeout at the minimum multiplier. The bench models a hard frequency ceiling: `pll_lock` is asserted only while `pll_en` is high and `mult` is at or below a chosen limit. Moving that limit walks the controller through any number of step-downs. The bench counts the falling edges of `pll_en` to confirm one drop per failed attempt. It then removes lock and changes every input after `done`, which shows the frozen result.

// File: rtl/mclk_mult_sel.sv
module mclk_mult_sel #(
  parameter int NCH      = 2,
  parameter int NSLOT    = 2,
  parameter int FW       = 12,
  parameter int MW       = 5,
  parameter int LW       = 16,
  parameter int MULT_MIN = 3,
  parameter int MULT_MAX = 12,
  parameter int REF_HI   = 133,
  parameter int REF_LO   = 100,
  localparam int ND = NCH * NSLOT,
  localparam int CW = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ND-1:0]    dimm_present,
  input  logic [ND*FW-1:0] std_fmax,
  input  logic [ND-1:0]    perf_avail,
  input  logic [ND-1:0]    perf_v15,
  input  logic [ND*FW-1:0] perf_fmax,
  input  logic [ND*CW-1:0] perf_lim,
  input  logic             cfg_ign_lim,
  input  logic             cfg_ign_fuse,
  input  logic [FW-1:0]    fuse_fmax,
  input  logic [FW-1:0]    board_fmax,
  input  logic             ref_sel,
  input  logic [LW-1:0]    lock_wait,
  input  logic             pll_lock,
  output logic [MW-1:0]    mult,
  output logic             pll_en,
  output logic             done,
  output logic             fail
);

  localparam logic [FW-1:0] MAX_F = FW'(MULT_MAX);
  localparam logic [FW-1:0] MIN_F = FW'(MULT_MIN);
  localparam logic [MW-1:0] MIN_M = MW'(MULT_MIN);

  typedef enum logic [2:0] {S_IDLE, S_TRY, S_DROP, S_LOCK, S_FAIL} st_t;

  st_t           st;
  logic [LW-1:0] cnt;
  logic [CW-1:0] ch_cnt [NCH];
  logic [FW-1:0] target, cap, clamped, quot, refv;
  logic          any;
  logic [MW-1:0] mult0;
  logic          tmo;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ch_cnt[c] = '0;
      for (int s = 0; s < NSLOT; s++)
        ch_cnt[c] = ch_cnt[c] + CW'(dimm_present[c*NSLOT+s]);
    end
    target = '1;
    any    = 1'b0;
    for (int i = 0; i < ND; i++) begin
      logic          usep;
      logic [FW-1:0] f;
      usep = perf_avail[i] && perf_v15[i] &&
             (cfg_ign_lim || ch_cnt[i/NSLOT] <= perf_lim[i*CW +: CW]);
      f = usep ? perf_fmax[i*FW +: FW] : std_fmax[i*FW +: FW];
      if (dimm_present[i]) begin
        any = 1'b1;
        if (f < target) target = f;
      end
    end
  end

  assign cap     = (board_fmax != '0) ? board_fmax : (cfg_ign_fuse ? '1 : fuse_fmax);
  assign clamped = (target < cap) ? target : cap;
  assign refv    = ref_sel ? FW'(REF_LO) : FW'(REF_HI);
  assign quot    = clamped / refv;
  assign mult0   = (quot > MAX_F) ? MW'(MULT_MAX) : quot[MW-1:0];
  assign tmo     = ({1'b0, cnt} + 1'b1) >= {1'b0, lock_wait};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      mult <= '0;
      cnt  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          if (!any || quot < MIN_F) st <= S_FAIL;
          else begin
            mult <= mult0;
            cnt  <= '0;
            st   <= S_TRY;
          end
        end
        S_TRY: begin
          if (pll_lock) st <= S_LOCK;
          else if (tmo) begin
            if (mult <= MIN_M) st <= S_FAIL;
            else begin
              mult <= mult - 1'b1;
              st   <= S_DROP;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_DROP: begin
          cnt <= '0;
          st  <= S_TRY;
        end
        default: st <= st;
      endcase
    end
  end

  assign pll_en = (st == S_TRY) || (st == S_LOCK);
  assign done   = (st == S_LOCK);
  assign fail   = (st == S_FAIL);

endmodule

// File: rtl/mclk_mult_sel_chk.sv
module mclk_mult_sel_chk #(
  parameter int MW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [MW-1:0] mult,
  input logic          pll_en,
  input logic          done,
  input logic          fail
);

  assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && pll_en && $stable(mult));

  assert_fail_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail && !pll_en);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  assert_mult_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en && $past(pll_en)) |-> $stable(mult));

  assert_step_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pll_en) && !fail) |-> (mult == $past(mult) - 1'b1));

endmodule

bind mclk_mult_sel mclk_mult_sel_chk #(.MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mult(mult), .pll_en(pll_en), .done(done), .fail(fail)
);

// File: tb/sim_mclk_mult_sel.sv
module sim_mclk_mult_sel;
  localparam int NCH = 2, NSLOT = 2, FW = 12, MW = 5, LW = 16;
  localparam int ND = NCH * NSLOT;
  localparam int CW = $clog2(NSLOT + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [ND-1:0] dimm_present, perf_avail, perf_v15;
  logic [ND*FW-1:0] std_fmax, perf_fmax;
  logic [ND*CW-1:0] perf_lim;
  logic cfg_ign_lim, cfg_ign_fuse, ref_sel;
  logic [FW-1:0] fuse_fmax, board_fmax;
  logic [LW-1:0] lock_wait;
  logic pll_lock;
  logic [MW-1:0] mult;
  logic pll_en, done, fail;
  int hard_lim;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign pll_lock = pll_en && (int'(mult) <= hard_lim);

  mclk_mult_sel u0 (.*);

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic set_all(input logic [FW-1:0] s, input logic [FW-1:0] p);
    for (int i = 0; i < ND; i++) begin
      std_fmax[i*FW +: FW]  = s;
      perf_fmax[i*FW +: FW] = p;
      perf_lim[i*CW +: CW]  = CW'(2);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 0;
    dimm_present = '1; perf_avail = '0; perf_v15 = '0;
    set_all(12'd800, 12'd1066);
    cfg_ign_lim = 0; cfg_ign_fuse = 0; ref_sel = 0;
    fuse_fmax = 12'd1066; board_fmax = '0; lock_wait = 16'd5;
    hard_lim = 31;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_case(string rq, int exp_m, bit exp_fail, int exp_falls);
    int falls = 0;
    logic prev;
    start = 1;
    @(negedge clk);
    start = 0;
    prev = pll_en;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (prev && !pll_en) falls++;
      prev = pll_en;
      if (done || fail) break;
    end
    chk({rq, " fail"}, fail, exp_fail);
    chk({rq, " done"}, done, !exp_fail);
    chk({rq, " mult"}, mult, exp_m);
    chk({rq, " drops"}, falls, exp_falls);
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R1 mult", mult, 0);
    chk("R1 pll_en", pll_en, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
  endtask

  task automatic t_min();
    reset_dut();
    std_fmax[0*FW +: FW] = 12'd800;  std_fmax[1*FW +: FW] = 12'd667;
    std_fmax[2*FW +: FW] = 12'd933;  std_fmax[3*FW +: FW] = 12'd1066;
    run_case("R4 slowest", 5, 0, 0);
  endtask

  task automatic t_perf();
    reset_dut();
    perf_avail = '1; perf_v15 = '1;
    run_case("R2 perf used", 8, 0, 0);
    reset_dut();
    perf_avail = '1; perf_v15 = '1;
    for (int i = 0; i < ND; i++) perf_lim[i*CW +: CW] = CW'(1);
    run_case("R2 count over limit", 6, 0, 0);
    reset_dut();
    perf_avail = '1; perf_v15 = '1; cfg_ign_lim = 1;
    for (int i = 0; i < ND; i++) perf_lim[i*CW +: CW] = CW'(1);
    run_case("R3 ignore limit", 8, 0, 0);
    reset_dut();
    perf_avail = '1; perf_v15 = 4'b1110;
    run_case("R2 voltage", 6, 0, 0);
  endtask

  task automatic t_ceiling();
    reset_dut();
    set_all(12'd1066, 12'd1066); fuse_fmax = 12'd800;
    run_case("R5 fuse clamp", 6, 0, 0);
    reset_dut();
    set_all(12'd1066, 12'd1066); fuse_fmax = 12'd800; cfg_ign_fuse = 1;
    run_case("R5 fuse ignored", 8, 0, 0);
    reset_dut();
    set_all(12'd1066, 12'd1066); fuse_fmax = 12'd800; board_fmax = 12'd933;
    run_case("R5 board override", 7, 0, 0);
  endtask

  task automatic t_ref();
    reset_dut();
    set_all(12'd1066, 12'd1066); ref_sel = 1;
    run_case("R6 ref 100", 10, 0, 0);
    reset_dut();
    set_all(12'd2000, 12'd2000); ref_sel = 1; cfg_ign_fuse = 1;
    run_case("R6 cap max", 12, 0, 0);
  endtask

  task automatic t_step();
    reset_dut();
    set_all(12'd1066, 12'd1066); hard_lim = 6;
    run_case("R7 step down", 6, 0, 2);
  endtask

  task automatic t_fail();
    reset_dut();
    set_all(12'd1066, 12'd1066); hard_lim = 2;
    run_case("R9 min timeout", 3, 1, 6);
    chk("R9 pll_en low", pll_en, 0);
    reset_dut();
    set_all(12'd300, 12'd300);
    run_case("R9 too slow", 0, 1, 0);
    reset_dut();
    dimm_present = '0;
    run_case("R9 no module", 0, 1, 0);
  endtask

  task automatic t_freeze();
    reset_dut();
    set_all(12'd1066, 12'd1066);
    run_case("R8 lock", 8, 0, 0);
    hard_lim = 0;
    set_all(12'd667, 12'd667);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    chk("R8 mult frozen", mult, 8);
    chk("R8 done held", done, 1);
    chk("R8 pll_en held", pll_en, 1);
    chk("R10 no fail", fail, 0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_min();
    t_perf();
    t_ceiling();
    t_ref();
    t_step();
    t_fail();
    t_freeze();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule